// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block switches a set of independent peripheral power domains on and off under software control. Software writes per-domain bits into a power-up trigger register or a power-down trigger register. The sequencer handles one pending domain at a time. It drives that domain's power-switch enable, isolation and local reset outputs through a timed sequence, and it clears the trigger bit when the sequence is complete, so software can poll the bit for completion. The timer counts rising edges of a slow clock of roughly 32 kHz. That clock is brought into the bus clock domain through a two-flop synchroniser with edge detection.

Some domains sit behind a bus bridge that must isolate them. For those domains the sequencer also runs a request/acknowledge handshake. On power-up the handshake runs after the switch sequence. On power-down it runs before the switch sequence. Domains built as always-on ignore power-down. A per-domain reset-hold input can hold a power-up at its last step. A mapping register selects which domains accept trigger writes, and a per-domain gating control bit must already be in the correct state before a trigger is accepted.

All control and status pins are plain levels. The register port is a simple single-cycle read/write port with no back-pressure: a write takes effect on the clock edge on which `reg_we` is high, and `reg_rdata` is a combinational function of `reg_addr`.

Top module: `power_gate_seq`

## Requirements
- R1: After reset, every domain has its switch enable low, isolation high, local reset asserted (`dom_rst_n` low) and handshake request low. All registers read zero.
- R2: Register map on word address `reg_addr`: 0 holds the gating control bits, 1 the up triggers, 2 the down triggers, 3 the domain mapping, 4 the timing, and 5 the status (read-only). Domain i uses bit i in every per-domain register.
- R3: The timing register holds the switch delay SW in bits [9:0] and the switch-to-isolation delay SW2ISO in bits [19:10]. On power-up, the switch enable rises first. Isolation is released and the local reset deasserted together, after SW + SW2ISO slow-clock rising edges.
- R4: Writing 1 to an up-trigger bit sets it only if the domain's mapping bit is 1 and its gating control bit is 0. Writing 1 to a down-trigger bit sets it only if the mapping bit is 1 and the gating control bit is 1. Any other trigger write is ignored.
- R5: A trigger bit stays 1 while its sequence runs and clears itself when the sequence ends. The status bit reads 1 only after a power-up has fully completed, and it reads 0 once a power-down has started.
- R6: For a handshake domain, power-up raises the request once isolation is released. Completion, with the trigger cleared and the status set, waits for the acknowledge to be high.
- R7: For a handshake domain, power-down first drops the request. Isolation and reset are asserted only after the acknowledge is seen low. The switch enable drops SW2ISO slow edges later, and the sequence ends SW slow edges after that. For a domain without the handshake, isolation and reset assert at once.
- R8: An always-on domain ignores a power-down trigger. The trigger bit clears, and the switch, isolation and status of the domain do not change.
- R9: While a domain's reset-hold input is high, its power-up does not release isolation or reset, and its up-trigger bit stays set.
- R10: Pending domains are served one at a time in ascending index order.
- R11: If both the up and the down trigger of a domain are pending when the domain is selected, the up bit is cleared with no action and only the power-down runs.
- R12: Isolation is never off while the switch is off, and the local reset is always asserted while the domain is isolated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk | input | 1 | Slow timing clock, asynchronous to clk |
| reg_addr | input | ADDR_W | Register word address |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| hsk_ack | input | NUM_DOM | Bridge acknowledge per domain |
| rst_hold | input | NUM_DOM | External reset-hold per domain |
| dom_sw_en | output | NUM_DOM | Power switch enable per domain |
| dom_iso | output | NUM_DOM | Isolation enable per domain |
| dom_rst_n | output | NUM_DOM | Active-low local reset per domain |
| hsk_req | output | NUM_DOM | Bridge request per domain, high means release isolation |

## Verification
A vector table drives power-up and power-down cycles on plain domains with four different SW/SW2ISO splits. Among them are a zero switch delay and a zero isolation delay, so a swapped field, a miscounted phase or a missing phase shows up as a wrong count of slow edges. The directed tests hold the acknowledge and the reset-hold inputs at the wrong level. This separates a sequencer that waits from one that runs ahead. The tests also queue several domains behind a held one, with one of them carrying both triggers, which exposes the serving order and the precedence of power-down. Trigger writes to unmapped domains, or with the wrong gating control bit, are read back to confirm they were dropped.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  localparam int unsigned FIELD_W = 10;

  typedef struct packed {
    logic [FIELD_W-1:0] sw2iso;
    logic [FIELD_W-1:0] sw;
  } timing_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UP_SW,
    ST_UP_ISO,
    ST_UP_HOLD,
    ST_UP_HSK,
    ST_DN_HSK,
    ST_DN_ISO,
    ST_DN_SW
  } seq_state_e;
endpackage

// File: rtl/pgs_tick_sync.sv
module pgs_tick_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow_clk,
  output logic tick
);
  logic [SYNC_STAGES:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= {shift_q[SYNC_STAGES-1:0], slow_clk};
  end

  assign tick = shift_q[SYNC_STAGES-1] & ~shift_q[SYNC_STAGES];
endmodule

// File: rtl/pgs_regs.sv
module pgs_regs
  import pgs_pkg::*;
#(
  parameter int unsigned NUM_DOM = 22,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               we,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  input  logic [NUM_DOM-1:0] clr_up,
  input  logic [NUM_DOM-1:0] clr_dn,
  input  logic [NUM_DOM-1:0] pwr_set,
  input  logic [NUM_DOM-1:0] pwr_clr,
  output logic [NUM_DOM-1:0] up_pend,
  output logic [NUM_DOM-1:0] dn_pend,
  output timing_t            timing
);
  localparam int unsigned TIME_W = 2 * FIELD_W;
  localparam logic [ADDR_W-1:0] A_GATE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_UP   = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_DN   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_MAP  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_TIME = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(5);

  logic [NUM_DOM-1:0] gate_q, up_q, dn_q, map_q, pwr_q;
  timing_t            time_q;
  logic [NUM_DOM-1:0] wd;
  logic [NUM_DOM-1:0] up_acc, dn_acc;
  logic               unused_wdata;

  assign wd           = wdata[NUM_DOM-1:0];
  assign unused_wdata = ^wdata;
  assign up_acc       = (we && addr == A_UP) ? (wd & map_q & ~gate_q) : '0;
  assign dn_acc       = (we && addr == A_DN) ? (wd & map_q & gate_q)  : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      up_q   <= '0;
      dn_q   <= '0;
      map_q  <= '0;
      pwr_q  <= '0;
      time_q <= '0;
    end else begin
      if (we && addr == A_GATE) gate_q <= wd;
      if (we && addr == A_MAP)  map_q  <= wd;
      if (we && addr == A_TIME) time_q <= wdata[TIME_W-1:0];
      up_q  <= (up_q | up_acc) & ~clr_up;
      dn_q  <= (dn_q | dn_acc) & ~clr_dn;
      pwr_q <= (pwr_q | pwr_set) & ~pwr_clr;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_GATE:  rdata[NUM_DOM-1:0] = gate_q;
      A_UP:    rdata[NUM_DOM-1:0] = up_q;
      A_DN:    rdata[NUM_DOM-1:0] = dn_q;
      A_MAP:   rdata[NUM_DOM-1:0] = map_q;
      A_TIME:  rdata[TIME_W-1:0]  = time_q;
      A_STAT:  rdata[NUM_DOM-1:0] = pwr_q;
      default: rdata = '0;
    endcase
  end

  assign up_pend = up_q;
  assign dn_pend = dn_q;
  assign timing  = time_q;
endmodule

// File: rtl/pgs_seq.sv
module pgs_seq
  import pgs_pkg::*;
#(
  parameter int unsigned        NUM_DOM   = 22,
  parameter logic [NUM_DOM-1:0] ALWAYS_ON = '0,
  parameter logic [NUM_DOM-1:0] NEED_HSK  = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic [NUM_DOM-1:0] up_pend,
  input  logic [NUM_DOM-1:0] dn_pend,
  input  timing_t            timing,
  input  logic [NUM_DOM-1:0] hsk_ack,
  input  logic [NUM_DOM-1:0] rst_hold,
  output logic [NUM_DOM-1:0] sw_en,
  output logic [NUM_DOM-1:0] iso,
  output logic [NUM_DOM-1:0] drst_n,
  output logic [NUM_DOM-1:0] req,
  output logic [NUM_DOM-1:0] clr_up,
  output logic [NUM_DOM-1:0] clr_dn,
  output logic [NUM_DOM-1:0] pwr_set,
  output logic [NUM_DOM-1:0] pwr_clr
);
  localparam int unsigned IDX_W = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1;

  seq_state_e         state_q, state_d;
  logic [IDX_W-1:0]   idx_q, idx_d, pick;
  logic [FIELD_W-1:0] cnt_q, cnt_d;
  logic [NUM_DOM-1:0] sw_q, sw_d, iso_q, iso_d, rst_q, rst_d, req_q, req_d;
  logic [NUM_DOM-1:0] pend;

  assign pend = up_pend | dn_pend;

  // lowest pending index wins
  always_comb begin
    pick = '0;
    for (int i = NUM_DOM - 1; i >= 0; i--) begin
      if (pend[i]) pick = IDX_W'(i);
    end
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    sw_d    = sw_q;
    iso_d   = iso_q;
    rst_d   = rst_q;
    req_d   = req_q;
    clr_up  = '0;
    clr_dn  = '0;
    pwr_set = '0;
    pwr_clr = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (|pend) begin
          idx_d = pick;
          cnt_d = '0;
          if (dn_pend[pick]) begin
            clr_up[pick] = 1'b1;
            if (ALWAYS_ON[pick]) begin
              clr_dn[pick] = 1'b1;
            end else begin
              pwr_clr[pick] = 1'b1;
              if (NEED_HSK[pick]) begin
                req_d[pick] = 1'b0;
                state_d     = ST_DN_HSK;
              end else begin
                iso_d[pick] = 1'b1;
                rst_d[pick] = 1'b0;
                state_d     = ST_DN_ISO;
              end
            end
          end else begin
            pwr_clr[pick] = 1'b1;
            sw_d[pick]    = 1'b1;
            state_d       = ST_UP_SW;
          end
        end
      end
      ST_UP_SW: begin
        if (cnt_q >= timing.sw) begin
          cnt_d   = '0;
          state_d = ST_UP_ISO;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_UP_ISO: begin
        if (cnt_q >= timing.sw2iso) state_d = ST_UP_HOLD;
        else if (tick)              cnt_d   = cnt_q + 1'b1;
      end
      ST_UP_HOLD: begin
        if (!rst_hold[idx_q]) begin
          iso_d[idx_q] = 1'b0;
          rst_d[idx_q] = 1'b1;
          if (NEED_HSK[idx_q]) begin
            req_d[idx_q] = 1'b1;
            state_d      = ST_UP_HSK;
          end else begin
            clr_up[idx_q]  = 1'b1;
            pwr_set[idx_q] = 1'b1;
            state_d        = ST_IDLE;
          end
        end
      end
      ST_UP_HSK: begin
        if (hsk_ack[idx_q]) begin
          clr_up[idx_q]  = 1'b1;
          pwr_set[idx_q] = 1'b1;
          state_d        = ST_IDLE;
        end
      end
      ST_DN_HSK: begin
        if (!hsk_ack[idx_q]) begin
          iso_d[idx_q] = 1'b1;
          rst_d[idx_q] = 1'b0;
          cnt_d        = '0;
          state_d      = ST_DN_ISO;
        end
      end
      ST_DN_ISO: begin
        if (cnt_q >= timing.sw2iso) begin
          sw_d[idx_q] = 1'b0;
          cnt_d       = '0;
          state_d     = ST_DN_SW;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DN_SW: begin
        if (cnt_q >= timing.sw) begin
          clr_dn[idx_q] = 1'b1;
          state_d       = ST_IDLE;
        end else if (tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      sw_q    <= '0;
      iso_q   <= '1;
      rst_q   <= '0;
      req_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      sw_q    <= sw_d;
      iso_q   <= iso_d;
      rst_q   <= rst_d;
      req_q   <= req_d;
    end
  end

  assign sw_en  = sw_q;
  assign iso    = iso_q;
  assign drst_n = rst_q;
  assign req    = req_q;
endmodule

// File: rtl/power_gate_seq.sv
module power_gate_seq
  import pgs_pkg::*;
#(
  parameter int unsigned        NUM_DOM   = 22,
  parameter int unsigned        ADDR_W    = 3,
  parameter int unsigned        DATA_W    = 32,
  parameter logic [NUM_DOM-1:0] ALWAYS_ON = 22'h00000C,
  parameter logic [NUM_DOM-1:0] NEED_HSK  = 22'h022271
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slow_clk,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_we,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_DOM-1:0] hsk_ack,
  input  logic [NUM_DOM-1:0] rst_hold,
  output logic [NUM_DOM-1:0] dom_sw_en,
  output logic [NUM_DOM-1:0] dom_iso,
  output logic [NUM_DOM-1:0] dom_rst_n,
  output logic [NUM_DOM-1:0] hsk_req
);
  logic               tick;
  logic [NUM_DOM-1:0] up_pend, dn_pend, clr_up, clr_dn, pwr_set, pwr_clr;
  timing_t            timing;

  pgs_tick_sync #(.SYNC_STAGES(2)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .slow_clk (slow_clk),
    .tick     (tick)
  );

  pgs_regs #(.NUM_DOM(NUM_DOM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (reg_addr),
    .we      (reg_we),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .clr_up  (clr_up),
    .clr_dn  (clr_dn),
    .pwr_set (pwr_set),
    .pwr_clr (pwr_clr),
    .up_pend (up_pend),
    .dn_pend (dn_pend),
    .timing  (timing)
  );

  pgs_seq #(.NUM_DOM(NUM_DOM), .ALWAYS_ON(ALWAYS_ON), .NEED_HSK(NEED_HSK)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .up_pend  (up_pend),
    .dn_pend  (dn_pend),
    .timing   (timing),
    .hsk_ack  (hsk_ack),
    .rst_hold (rst_hold),
    .sw_en    (dom_sw_en),
    .iso      (dom_iso),
    .drst_n   (dom_rst_n),
    .req      (hsk_req),
    .clr_up   (clr_up),
    .clr_dn   (clr_dn),
    .pwr_set  (pwr_set),
    .pwr_clr  (pwr_clr)
  );
endmodule

// File: rtl/pgs_checker.sv
module pgs_checker #(
  parameter int unsigned        NUM_DOM   = 22,
  parameter logic [NUM_DOM-1:0] ALWAYS_ON = '0,
  parameter logic [NUM_DOM-1:0] NEED_HSK  = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_DOM-1:0] dom_sw_en,
  input logic [NUM_DOM-1:0] dom_iso,
  input logic [NUM_DOM-1:0] dom_rst_n,
  input logic [NUM_DOM-1:0] hsk_req,
  input logic [NUM_DOM-1:0] hsk_ack,
  input logic [NUM_DOM-1:0] rst_hold
);
  AST_ISO_WHILE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (~dom_sw_en & ~dom_iso) == '0); // R12
  AST_RST_WHILE_ISO: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_iso & dom_rst_n) == '0); // R12
  AST_REQ_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (hsk_req & dom_iso) == '0); // R6
  AST_ISO_FALL_NEEDS_SW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dom_iso) & ~dom_iso & ~$past(dom_sw_en)) == '0); // R3
  AST_DN_WAITS_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (~$past(dom_iso) & dom_iso & NEED_HSK & $past(hsk_ack)) == '0); // R7
  AST_HOLD_BLOCKS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dom_iso) & ~dom_iso & $past(rst_hold)) == '0); // R9
  AST_ALWAYS_ON_STAYS_UP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dom_sw_en) & ~dom_sw_en & ALWAYS_ON) == '0); // R8
endmodule

bind power_gate_seq pgs_checker #(
  .NUM_DOM(NUM_DOM), .ALWAYS_ON(ALWAYS_ON), .NEED_HSK(NEED_HSK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dom_sw_en (dom_sw_en),
  .dom_iso   (dom_iso),
  .dom_rst_n (dom_rst_n),
  .hsk_req   (hsk_req),
  .hsk_ack   (hsk_ack),
  .rst_hold  (rst_hold)
);

// File: tb/power_gate_seq_tb.sv
module power_gate_seq_tb;
  localparam int ND = 22;
  localparam logic [2:0] A_GATE = 3'd0, A_UP = 3'd1, A_DN = 3'd2,
                         A_MAP = 3'd3, A_TIME = 3'd4, A_STAT = 3'd5;
  localparam int NV = 4;
  localparam int VEC_DOM [NV] = '{1, 7, 10, 11};
  localparam int VEC_SW  [NV] = '{1, 2, 0, 3};
  localparam int VEC_ISO [NV] = '{1, 3, 4, 0};
  localparam int VEC_EXP [NV] = '{2, 5, 4, 3};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slow_clk = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [ND-1:0] hsk_ack = '0;
  logic [ND-1:0] rst_hold = '0;
  logic [ND-1:0] dom_sw_en, dom_iso, dom_rst_n, hsk_req;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  power_gate_seq u_dut (
    .clk(clk), .rst_n(rst_n), .slow_clk(slow_clk), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hsk_ack(hsk_ack), .rst_hold(rst_hold), .dom_sw_en(dom_sw_en),
    .dom_iso(dom_iso), .dom_rst_n(dom_rst_n), .hsk_req(hsk_req)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic slow_edges(input int n);
    for (int k = 0; k < n; k++) begin
      slow_clk = 1'b1; repeat (4) @(negedge clk);
      slow_clk = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] r;
    int n;
    int d;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);

    // R1 reset state
    chk("R1 sw_en", 32'(dom_sw_en), 32'h0);
    chk("R1 iso", 32'(dom_iso), 32'h3FFFFF);
    chk("R1 rst_n", 32'(dom_rst_n), 32'h0);
    chk("R1 req", 32'(hsk_req), 32'h0);
    rd(A_STAT, r); chk("R1 status", r, 32'h0);
    rd(A_MAP, r);  chk("R1 map", r, 32'h0);

    // R4 unmapped up write ignored; R2 map register
    wr(A_UP, 32'h2);
    rd(A_UP, r); chk("R4 unmapped up ignored", r, 32'h0);
    chk("R4 no switch on unmapped", 32'(dom_sw_en[1]), 32'h0);
    wr(A_MAP, 32'h3FFFFF);
    rd(A_MAP, r); chk("R2 map readback", r, 32'h3FFFFF);
    // R4 down with gating control clear ignored
    wr(A_DN, 32'h2);
    rd(A_DN, r); chk("R4 down with gate clear ignored", r, 32'h0);

    // R3 R5 R7: vector table of plain domains
    for (int v = 0; v < NV; v++) begin
      d = VEC_DOM[v];
      wr(A_TIME, 32'((VEC_ISO[v] << 10) | VEC_SW[v]));
      rd(A_TIME, r); chk("R3 timing readback", r, 32'((VEC_ISO[v] << 10) | VEC_SW[v]));
      wr(A_UP, 32'(1) << d);
      wait_cyc(2);
      chk("R3 switch on first", 32'(dom_sw_en[d]), 32'h1);
      rd(A_UP, r); chk("R5 up bit held", r[d], 32'h1);
      n = 0;
      while (dom_iso[d] !== 1'b0 && n < 20) begin slow_edges(1); n++; end
      chk("R3 up slow edges", 32'(n), 32'(VEC_EXP[v]));
      chk("R3 reset released", 32'(dom_rst_n[d]), 32'h1);
      rd(A_UP, r); chk("R5 up bit cleared", r[d], 32'h0);
      rd(A_STAT, r); chk("R5 status on", r[d], 32'h1);
      wr(A_GATE, 32'(1) << d);
      wr(A_DN, 32'(1) << d);
      wait_cyc(2);
      chk("R7 iso at once", 32'(dom_iso[d]), 32'h1);
      chk("R7 reset at once", 32'(dom_rst_n[d]), 32'h0);
      rd(A_STAT, r); chk("R5 status off", r[d], 32'h0);
      n = 0;
      rd(A_DN, r);
      while (r[d] !== 1'b0 && n < 20) begin slow_edges(1); n++; rd(A_DN, r); end
      chk("R7 down slow edges", 32'(n), 32'(VEC_EXP[v]));
      chk("R7 switch off", 32'(dom_sw_en[d]), 32'h0);
      wr(A_GATE, 32'h0);
    end

    // R6 handshake on power-up, domain 0
    wr(A_TIME, 32'h401);
    wr(A_UP, 32'h1);
    slow_edges(2);
    chk("R6 iso released", 32'(dom_iso[0]), 32'h0);
    chk("R6 request raised", 32'(hsk_req[0]), 32'h1);
    wait_cyc(4);
    rd(A_UP, r); chk("R6 waits for ack", r[0], 32'h1);
    rd(A_STAT, r); chk("R6 status not yet", r[0], 32'h0);
    hsk_ack[0] = 1'b1;
    wait_cyc(3);
    rd(A_UP, r); chk("R6 done after ack", r[0], 32'h0);
    rd(A_STAT, r); chk("R6 status on", r[0], 32'h1);

    // R7 handshake on power-down
    wr(A_GATE, 32'h1);
    wr(A_DN, 32'h1);
    wait_cyc(3);
    chk("R7 request dropped", 32'(hsk_req[0]), 32'h0);
    chk("R7 iso waits ack low", 32'(dom_iso[0]), 32'h0);
    hsk_ack[0] = 1'b0;
    wait_cyc(3);
    chk("R7 iso after ack low", 32'(dom_iso[0]), 32'h1);
    slow_edges(2);
    rd(A_DN, r); chk("R7 handshake down done", r[0], 32'h0);
    chk("R7 switch off", 32'(dom_sw_en[0]), 32'h0);
    wr(A_GATE, 32'h0);

    // R8 always-on domain 2
    wr(A_UP, 32'h4);
    slow_edges(2);
    wait_cyc(2);
    wr(A_GATE, 32'h4);
    wr(A_DN, 32'h4);
    wait_cyc(3);
    rd(A_DN, r); chk("R8 down trigger cleared", r[2], 32'h0);
    chk("R8 switch stays on", 32'(dom_sw_en[2]), 32'h1);
    chk("R8 iso stays off", 32'(dom_iso[2]), 32'h0);
    rd(A_STAT, r); chk("R8 status kept", r[2], 32'h1);
    wr(A_GATE, 32'h0);

    // R9 reset hold on domain 12
    rst_hold[12] = 1'b1;
    wr(A_UP, 32'(1) << 12);
    slow_edges(4);
    chk("R9 iso held", 32'(dom_iso[12]), 32'h1);
    rd(A_UP, r); chk("R9 trigger kept", r[12], 32'h1);
    rst_hold[12] = 1'b0;
    wait_cyc(3);
    chk("R9 released after hold", 32'(dom_iso[12]), 32'h0);
    rd(A_UP, r); chk("R9 trigger cleared", r[12], 32'h0);

    // R10 R11: queue behind held domain 15
    rst_hold[15] = 1'b1;
    wr(A_UP, 32'(1) << 15);
    slow_edges(2);
    wr(A_UP, (32'(1) << 18) | (32'(1) << 16) | (32'(1) << 14));
    wr(A_GATE, 32'(1) << 14);
    wr(A_DN, 32'(1) << 14);
    rd(A_UP, r); chk("R11 both pending", 32'(r[14]), 32'h1);
    rst_hold[15] = 1'b0;
    wait_cyc(3);
    rd(A_UP, r); chk("R11 up dropped", r[14], 32'h0);
    chk("R11 no switch on", 32'(dom_sw_en[14]), 32'h0);
    chk("R10 16 waits", 32'(dom_sw_en[16]), 32'h0);
    chk("R10 18 waits", 32'(dom_sw_en[18]), 32'h0);
    slow_edges(2);
    rd(A_DN, r); chk("R11 down done", r[14], 32'h0);
    chk("R10 16 served next", 32'(dom_sw_en[16]), 32'h1);
    chk("R10 18 still waits", 32'(dom_sw_en[18]), 32'h0);
    slow_edges(2);
    chk("R10 16 done", 32'(dom_iso[16]), 32'h0);
    chk("R10 18 served last", 32'(dom_sw_en[18]), 32'h1);
    slow_edges(2);
    rd(A_UP, r); chk("R10 queue empty", r, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule